// File: doc/BRIEF.md
# DRAM Strobe Cycle Classifier

This block is a passive observer placed beside an asynchronous DRAM. It samples the row strobe, the two byte-lane column strobes, the write enable and the output enable (all active low) on a fast system clock, and never drives any of them. Each time the row strobe is asserted, it follows the order in which the other strobes change. When the row strobe is released, it reports what kind of memory cycle took place and which byte lanes were involved.

The two column strobes are combined into a single column-active condition. This condition starts when either strobe falls and lasts while either is low. The first fall of this combined condition inside a row cycle is the reference point for classifying the cycle. The write and output-enable behaviour around that point then picks one of seven cycle kinds. The lane flags are kept separately for each byte strobe, so a word access shows both flags set.

Each result is a 3-bit code plus two lane flags. The result is registered when the row strobe rises, is marked by a one-clock done pulse, and is held until the next result replaces it. Every input passes through a two-stage synchroniser. Edges that reach the block on the same sample count as simultaneous, and a column strobe that arrives together with the row strobe is taken as having come first.

Top module: `dram_cycle_classifier`

## Requirements
- R1: While reset is asserted and after it is released, until the first cycle completes, `cyc_type` is 0 and `lane_lo`, `lane_hi` and `cyc_done` are 0.
- R2: `cyc_done` is high for exactly one clock. It rises on the third rising clock edge after the raw row strobe goes high, with that edge counted from the first edge that samples the new level.
- R3: `cyc_type` and the lane flags change only together with `cyc_done`, and hold their value until the next completed cycle.
- R4: If either column strobe, or both, is low on the sample where the row strobe is first seen low, the cycle is a column-before-row refresh, code 5. This includes the case where the two strobes fall on the same sample.
- R5: If neither column strobe goes low while the row strobe is low, the cycle is a row-only refresh, code 6, and both lane flags are 0.
- R6: If write enable is low on the sample where the combined column strobe first falls, the cycle is an early write, code 2.
- R7: If write enable falls after the combined column fall and output enable stayed high until then, the cycle is a delayed write, code 3.
- R8: If output enable was low at some sample from the combined column fall up to the write enable fall, the cycle is a read-modify-write, code 4.
- R9: If write enable stays high and output enable is low on some sample from the combined column fall onward, the cycle is a read, code 1.
- R10: If write enable stays high and output enable stays high from the combined column fall onward, the cycle is an output-disabled read, code 7.
- R11: `lane_lo` is set when the lower column strobe was low on any sample while the row strobe was low. `lane_hi` is set the same way from the upper column strobe. Both set means a word access.
- R12: Only the first fall of the combined column strobe sets the reference point. A later fall of the other byte strobe does not reclassify the cycle as an early write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ras_n | input | 1 | Row strobe, active low, asynchronous |
| ucas_n | input | 1 | Upper byte column strobe, active low |
| lcas_n | input | 1 | Lower byte column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| cyc_type | output | 3 | Code of the last completed cycle |
| lane_lo | output | 1 | Lower byte lane took part |
| lane_hi | output | 1 | Upper byte lane took part |
| cyc_done | output | 1 | One-clock pulse when a cycle result is posted |

## Verification
A strobe change becomes visible to the classifier two clock edges after it is driven, because of the synchroniser. The registered result and the done pulse follow on the third edge. The bench drives strobes on falling clock edges and holds each level for four clocks, so that every change is sampled before the next one. After releasing the row strobe, it checks that done is still low two falling edges later. It then checks that the code, the lanes and done are correct at the third falling edge, and that done has dropped with the code unchanged at the fourth.

// File: rtl/dcc_pkg.sv
package dcc_pkg;

  // bit positions inside the synchronised strobe bus
  localparam int STB_W    = 5;
  localparam int IX_ROW   = 0;
  localparam int IX_COLHI = 1;
  localparam int IX_COLLO = 2;
  localparam int IX_WR    = 3;
  localparam int IX_OUT   = 4;

  typedef enum logic [2:0] {
    CYC_NONE  = 3'd0,
    CYC_READ  = 3'd1,
    CYC_EWR   = 3'd2,
    CYC_DWR   = 3'd3,
    CYC_RMW   = 3'd4,
    CYC_CBR   = 3'd5,
    CYC_ROW   = 3'd6,
    CYC_RDZ   = 3'd7
  } cyc_e;

  // observations gathered while the row strobe is low
  typedef struct packed {
    logic cbr;       // column low when row fell
    logic col_seen;  // combined column fall occurred
    logic early;     // write low at that fall
    logic late;      // write fell afterwards
    logic rmw;       // output enable was low before late write
    logic oe_lo;     // output enable seen low since column fall
    logic lo;        // lower lane active
    logic hi;        // upper lane active
  } trk_t;

  function automatic cyc_e classify(input trk_t t);
    if (t.cbr)           return CYC_CBR;
    else if (!t.col_seen) return CYC_ROW;
    else if (t.early)    return CYC_EWR;
    else if (t.late)     return t.rmw ? CYC_RMW : CYC_DWR;
    else if (t.oe_lo)    return CYC_READ;
    else                 return CYC_RDZ;
  endfunction

endpackage

// File: rtl/dcc_sync.sv
module dcc_sync #(
  parameter int W     = 5,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) stg[0] <= '1;
    else        stg[0] <= d;
  end

  for (genvar i = 1; i < DEPTH; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) stg[i] <= '1;
      else        stg[i] <= stg[i-1];
    end
  end

  assign q = stg[DEPTH-1];
endmodule

// File: rtl/dcc_edges.sv
module dcc_edges (
  input  logic clk,
  input  logic rst_n,
  input  logic s_row_n,
  input  logic s_colhi_n,
  input  logic s_collo_n,
  output logic row_fall,
  output logic row_rise,
  output logic col_low
);
  logic row_prev;

  always_ff @(posedge clk) begin
    if (!rst_n) row_prev <= 1'b1;
    else        row_prev <= s_row_n;
  end

  assign row_fall = row_prev & ~s_row_n;
  assign row_rise = ~row_prev & s_row_n;
  // combined column strobe: active while either byte strobe is low
  assign col_low  = ~s_colhi_n | ~s_collo_n;
endmodule

// File: rtl/dcc_track.sv
module dcc_track
  import dcc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic s_row_n,
  input  logic s_colhi_n,
  input  logic s_collo_n,
  input  logic s_wr_n,
  input  logic s_out_n,
  input  logic row_fall,
  input  logic col_low,
  output trk_t trk,
  output logic col_first
);
  trk_t nxt;

  assign col_first = ~s_row_n & ~row_fall & ~trk.cbr & ~trk.col_seen & col_low;

  always_comb begin
    nxt = trk;
    if (row_fall) begin
      nxt     = '0;
      nxt.cbr = col_low;
      nxt.lo  = ~s_collo_n;
      nxt.hi  = ~s_colhi_n;
    end else if (!s_row_n) begin
      nxt.lo = trk.lo | ~s_collo_n;
      nxt.hi = trk.hi | ~s_colhi_n;
      if (col_first) begin
        nxt.col_seen = 1'b1;
        nxt.early    = ~s_wr_n;
        nxt.oe_lo    = ~s_out_n;
      end else if (trk.col_seen && !trk.early && !trk.late && !trk.cbr) begin
        nxt.oe_lo = trk.oe_lo | ~s_out_n;
        if (!s_wr_n) begin
          nxt.late = 1'b1;
          nxt.rmw  = trk.oe_lo | ~s_out_n;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) trk <= '0;
    else        trk <= nxt;
  end
endmodule

// File: rtl/dram_cycle_classifier.sv
module dram_cycle_classifier
  import dcc_pkg::*;
#(
  parameter int SYNC_DEPTH = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ras_n,
  input  logic       ucas_n,
  input  logic       lcas_n,
  input  logic       we_n,
  input  logic       oe_n,
  output logic [2:0] cyc_type,
  output logic       lane_lo,
  output logic       lane_hi,
  output logic       cyc_done
);
  logic [STB_W-1:0] raw_bus, s_bus;
  logic row_fall, row_rise, col_low, col_first;
  trk_t trk;

  always_comb begin
    raw_bus           = '1;
    raw_bus[IX_ROW]   = ras_n;
    raw_bus[IX_COLHI] = ucas_n;
    raw_bus[IX_COLLO] = lcas_n;
    raw_bus[IX_WR]    = we_n;
    raw_bus[IX_OUT]   = oe_n;
  end

  dcc_sync #(.W(STB_W), .DEPTH(SYNC_DEPTH)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_bus), .q(s_bus)
  );

  dcc_edges u_edges (
    .clk(clk), .rst_n(rst_n),
    .s_row_n(s_bus[IX_ROW]), .s_colhi_n(s_bus[IX_COLHI]), .s_collo_n(s_bus[IX_COLLO]),
    .row_fall(row_fall), .row_rise(row_rise), .col_low(col_low)
  );

  dcc_track u_track (
    .clk(clk), .rst_n(rst_n),
    .s_row_n(s_bus[IX_ROW]), .s_colhi_n(s_bus[IX_COLHI]), .s_collo_n(s_bus[IX_COLLO]),
    .s_wr_n(s_bus[IX_WR]), .s_out_n(s_bus[IX_OUT]),
    .row_fall(row_fall), .col_low(col_low),
    .trk(trk), .col_first(col_first)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cyc_type <= CYC_NONE;
      lane_lo  <= 1'b0;
      lane_hi  <= 1'b0;
      cyc_done <= 1'b0;
    end else begin
      cyc_done <= row_rise;
      if (row_rise) begin
        cyc_type <= classify(trk);
        lane_lo  <= trk.lo;
        lane_hi  <= trk.hi;
      end
    end
  end
endmodule

// File: rtl/dcc_checker.sv
module dcc_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] cyc_type,
  input logic       lane_lo,
  input logic       lane_hi,
  input logic       cyc_done,
  input logic       row_rise,
  input logic       col_first
);
  // R2: done follows the internal row-rise event by one clock
  assert_done_after_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    row_rise |=> cyc_done);

  // R2: done lasts a single clock
  assert_done_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_done |=> !cyc_done);

  // R3: result held between done pulses
  assert_type_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_done |-> ($stable(cyc_type) && $stable(lane_lo) && $stable(lane_hi)));

  // R3: a posted result is never the idle code
  assert_done_coded_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_done |-> cyc_type != 3'd0);

  // R5: row-only refresh reports no lanes
  assert_row_only_nolane_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_done && cyc_type == 3'd6) |-> (!lane_lo && !lane_hi));

  // R11: any column-driven cycle reports at least one lane
  assert_lane_present_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_done && cyc_type != 3'd6) |-> (lane_lo || lane_hi));

  // R12: the column reference point is marked at most once per row cycle
  assert_col_first_once_R12: assert property (@(posedge clk) disable iff (!rst_n)
    col_first |=> !col_first);
endmodule

bind dram_cycle_classifier dcc_checker u_chk (
  .clk(clk), .rst_n(rst_n), .cyc_type(cyc_type), .lane_lo(lane_lo),
  .lane_hi(lane_hi), .cyc_done(cyc_done), .row_rise(row_rise), .col_first(col_first)
);

// File: tb/sim_dram_cycle_classifier.sv
module sim_dram_cycle_classifier;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ras_n = 1'b1, ucas_n = 1'b1, lcas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [2:0] cyc_type;
  logic lane_lo, lane_hi, cyc_done;
  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  dram_cycle_classifier u0 (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .ucas_n(ucas_n), .lcas_n(lcas_n),
    .we_n(we_n), .oe_n(oe_n), .cyc_type(cyc_type), .lane_lo(lane_lo),
    .lane_hi(lane_hi), .cyc_done(cyc_done)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // release the row strobe and verify the posted result
  task automatic finish_cycle(input string req, input int exp_type, input int exp_lo, input int exp_hi);
    ras_n = 1'b1; ucas_n = 1'b1; lcas_n = 1'b1;
    step(2);
    chk("R2", "done early", int'(cyc_done), 0);
    step(1);
    chk("R2", "done pulse", int'(cyc_done), 1);
    chk(req, "cycle type", int'(cyc_type), exp_type);
    chk("R11", "lane_lo", int'(lane_lo), exp_lo);
    chk("R11", "lane_hi", int'(lane_hi), exp_hi);
    step(1);
    chk("R2", "done width", int'(cyc_done), 0);
    chk("R3", "type held", int'(cyc_type), exp_type);
    we_n = 1'b1; oe_n = 1'b1;
    step(4);
  endtask

  task automatic t_reset;
    step(3);
    chk("R1", "type in reset", int'(cyc_type), 0);
    chk("R1", "done in reset", int'(cyc_done), 0);
    rst_n = 1'b1;
    step(4);
    chk("R1", "type after reset", int'(cyc_type), 0);
    chk("R1", "lanes after reset", int'({lane_hi, lane_lo}), 0);
    chk("R1", "done after reset", int'(cyc_done), 0);
  endtask

  task automatic t_read_word;  // R9
    oe_n = 1'b0; ras_n = 1'b0; step(4);
    ucas_n = 1'b0; lcas_n = 1'b0; step(4);
    finish_cycle("R9", 1, 1, 1);
  endtask

  task automatic t_noout_lo;  // R10
    ras_n = 1'b0; step(4);
    lcas_n = 1'b0; step(4);
    finish_cycle("R10", 7, 1, 0);
  endtask

  task automatic t_early_hi;  // R6
    we_n = 1'b0; ras_n = 1'b0; step(4);
    ucas_n = 1'b0; step(4);
    finish_cycle("R6", 2, 0, 1);
  endtask

  task automatic t_delayed;  // R7
    ras_n = 1'b0; step(4);
    ucas_n = 1'b0; lcas_n = 1'b0; step(4);
    we_n = 1'b0; step(4);
    finish_cycle("R7", 3, 1, 1);
  endtask

  task automatic t_rmw;  // R8
    ras_n = 1'b0; step(4);
    ucas_n = 1'b0; lcas_n = 1'b0; oe_n = 1'b0; step(4);
    oe_n = 1'b1; step(4);
    we_n = 1'b0; step(4);
    finish_cycle("R8", 4, 1, 1);
  endtask

  task automatic t_cbr_one;  // R4
    lcas_n = 1'b0; step(4);
    ras_n = 1'b0; step(4);
    finish_cycle("R4", 5, 1, 0);
  endtask

  task automatic t_cbr_same;  // R4 simultaneous edges
    ras_n = 1'b0; ucas_n = 1'b0; step(4);
    finish_cycle("R4", 5, 0, 1);
  endtask

  task automatic t_row_only;  // R5
    we_n = 1'b0; oe_n = 1'b0; ras_n = 1'b0; step(6);
    finish_cycle("R5", 6, 0, 0);
  endtask

  task automatic t_first_col;  // R12
    ras_n = 1'b0; step(4);
    lcas_n = 1'b0; step(4);
    we_n = 1'b0; step(4);
    ucas_n = 1'b0; step(4);
    finish_cycle("R12", 3, 1, 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog run did not complete actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_read_word();
    t_noout_lo();
    t_early_hi();
    t_delayed();
    t_rmw();
    t_cbr_one();
    t_cbr_same();
    t_row_only();
    t_first_col();
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule